// File: doc/BRIEF.md
# Resistance-to-Frequency Measurement Counter

This block measures how fast an external RC oscillator runs. Software first writes an initial count and a gate length, then issues a start. The block synchronizes the free-running oscillator input into the system clock domain and adds one to a measurement counter on every rising edge it detects. A time base counter, clocked by the reference (system) clock, counts the length of the gate. When the gate ends, software reads the frozen count and derives the resistance from it.

Either counter can run past its top value. If either one does, the conversion stops at that edge, and a sticky flag records which counter overflowed. A normal end of the gate sets a separate done flag instead. The interrupt line stays high for as long as any of the three flags is set. Software clears each flag by pulsing its own clear input.

A gate length of zero selects free-running mode. In that mode the conversion ends only when one of the two counters overflows.

Top module: `rf_meas`

## Requirements
- R1: After reset, busy, all three flags, irq and mc_value are all 0.
- R2: A start while idle loads the measurement counter from the stored preset and raises busy on the next edge. For a nonzero gate_len, busy stays high for exactly gate_len clock cycles and then falls. On that same edge, done_flag is set.
- R3: Each rising edge of osc_in that arrives while busy adds one to the measurement counter. The input passes through a two-flop synchronizer and an edge detector, so the count changes on the third clock edge after osc_in rises.
- R4: While busy is low, mc_value holds the result of the last conversion, whatever osc_in does.
- R5: A start that arrives while busy has no effect. Neither the count nor the gate length changes.
- R6: A preset write while busy is ignored. The next conversion starts from the preset that was held before.
- R7: When the measurement counter increments from all ones, it wraps to 0. The conversion ends on that edge, mc_ovf_flag is set, and done_flag is not set.
- R8: With gate_len = 0, the time base counter runs free. Its wrap after 2^TB_W busy cycles ends the conversion, sets tb_ovf_flag, and leaves done_flag clear.
- R9: Each flag is sticky. A pulse on its own clear input clears it and leaves the other flags unchanged. If a set and a clear arrive in the same cycle, the set wins.
- R10: irq is high exactly while at least one of done_flag, mc_ovf_flag and tb_ovf_flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System / reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_in | input | 1 | RC oscillator output, asynchronous |
| preset_wr | input | 1 | Store preset_val as the initial count (idle only) |
| preset_val | input | MC_W | Initial measurement count |
| gate_len | input | TB_W | Gate length in clock cycles; 0 = free-running |
| start | input | 1 | Start a conversion (idle only) |
| clr_done | input | 1 | Clear done_flag |
| clr_mc_ovf | input | 1 | Clear mc_ovf_flag |
| clr_tb_ovf | input | 1 | Clear tb_ovf_flag |
| busy | output | 1 | Conversion in progress |
| mc_value | output | MC_W | Measurement counter value |
| done_flag | output | 1 | Sticky normal-end flag |
| mc_ovf_flag | output | 1 | Sticky measurement overflow flag |
| tb_ovf_flag | output | 1 | Sticky time base overflow flag |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check these properties on every cycle:
- a detected edge lasts only one cycle;
- both counters step by exactly one when enabled;
- the count stays frozen while idle;
- a second start cannot disturb a running gate;
- an overflow aborts the conversion on the following edge;
- every fall of busy comes with a flag;
- irq follows the flags.

Only the directed scenarios can show the things that need a reference outside the design:
- the exact gate length;
- the final count after a known number of oscillator pulses;
- that a preset written while busy carries no weight in the next conversion;
- the full 2^TB_W-cycle free-running wrap;
- that each clear input touches only its own flag.

// File: rtl/rf_pkg.sv
package rf_pkg;
   typedef enum logic [1:0] {
      END_NONE   = 2'd0,
      END_GATE   = 2'd1,
      END_OVF    = 2'd2
   } end_cause_e;
endpackage

// File: rtl/rf_edge_sync.sv
module rf_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rf_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= async_in;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[i] <= 1'b0;
               else        chain_q[i] <= chain_q[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[STAGES-1];

   assign rise = chain_q[STAGES-1] & ~prev_q;

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise); // R3
endmodule

// File: rtl/rf_counter.sv
module rf_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         inc,
   output logic [W-1:0] q,
   output logic         wrap
);
   generate
      if (W < 2) begin : g_bad_width
         $error("rf_counter: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] q_r;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)    q_r <= '0;
      else if (load) q_r <= load_val;
      else if (inc)  q_r <= q_r + 1'b1;

   assign q    = q_r;
   assign wrap = inc & (&q_r);

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load) |=> q_r == $past(q_r) + 1'b1); // R3
endmodule

// File: rtl/rf_meas.sv
module rf_meas #(
   parameter int MC_W        = 20,
   parameter int TB_W        = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            osc_in,
   input  logic            preset_wr,
   input  logic [MC_W-1:0] preset_val,
   input  logic [TB_W-1:0] gate_len,
   input  logic            start,
   input  logic            clr_done,
   input  logic            clr_mc_ovf,
   input  logic            clr_tb_ovf,
   output logic            busy,
   output logic [MC_W-1:0] mc_value,
   output logic            done_flag,
   output logic            mc_ovf_flag,
   output logic            tb_ovf_flag,
   output logic            irq
);
   import rf_pkg::*;

   localparam logic [TB_W-1:0] GATE_FREE = '0;

   generate
      if (MC_W < 2 || MC_W > 32) begin : g_bad_mc
         $error("rf_meas: MC_W out of range");
      end
      if (TB_W < 2 || TB_W > 24) begin : g_bad_tb
         $error("rf_meas: TB_W out of range");
      end
   endgenerate

   logic            busy_q, done_q, mc_ovf_q, tb_ovf_q;
   logic [MC_W-1:0] preset_q;
   logic [MC_W-1:0] mc_q;
   logic [TB_W-1:0] tb_q;
   logic            osc_rise, mc_wrap, tb_wrap;
   logic            start_ok, gate_hit;
   end_cause_e      cause;

   assign start_ok = start & ~busy_q;
   assign gate_hit = busy_q && (gate_len != GATE_FREE) && (tb_q == gate_len - 1'b1);

   always_comb begin
      if (mc_wrap || tb_wrap) cause = END_OVF;
      else if (gate_hit)      cause = END_GATE;
      else                    cause = END_NONE;
   end

   rf_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(osc_in), .rise(osc_rise)
   );

   rf_counter #(.W(MC_W)) u_mc (
      .clk(clk), .rst_n(rst_n), .load(start_ok), .load_val(preset_q),
      .inc(busy_q & osc_rise), .q(mc_q), .wrap(mc_wrap)
   );

   rf_counter #(.W(TB_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .load(start_ok), .load_val('0),
      .inc(busy_q), .q(tb_q), .wrap(tb_wrap)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                     preset_q <= '0;
      else if (preset_wr && !busy_q)  preset_q <= preset_val;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                 busy_q <= 1'b0;
      else if (start_ok)          busy_q <= 1'b1;
      else if (cause != END_NONE) busy_q <= 1'b0;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         done_q   <= 1'b0;
         mc_ovf_q <= 1'b0;
         tb_ovf_q <= 1'b0;
      end else begin
         if (cause == END_GATE) done_q <= 1'b1;
         else if (clr_done)     done_q <= 1'b0;
         if (mc_wrap)           mc_ovf_q <= 1'b1;
         else if (clr_mc_ovf)   mc_ovf_q <= 1'b0;
         if (tb_wrap)           tb_ovf_q <= 1'b1;
         else if (clr_tb_ovf)   tb_ovf_q <= 1'b0;
      end

   assign busy        = busy_q;
   assign mc_value    = mc_q;
   assign done_flag   = done_q;
   assign mc_ovf_flag = mc_ovf_q;
   assign tb_ovf_flag = tb_ovf_q;
   assign irq         = done_q | mc_ovf_q | tb_ovf_q;

   AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(mc_value)); // R4
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && cause == END_NONE) |=> (busy && tb_q == $past(tb_q) + 1'b1)); // R5
   AST_MC_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      mc_wrap |=> (!busy && mc_ovf_flag && mc_value == '0)); // R7
   AST_TB_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      tb_wrap |=> (!busy && tb_ovf_flag)); // R8
   AST_END_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done_flag || mc_ovf_flag || tb_ovf_flag)); // R2
   AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (done_flag || mc_ovf_flag || tb_ovf_flag) |-> irq); // R10
endmodule

// File: tb/sim_rf_meas.sv
module sim_rf_meas;
   localparam int MC_W = 20;
   localparam int TB_W = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            osc_in = 1'b0;
   logic            preset_wr = 1'b0;
   logic [MC_W-1:0] preset_val = '0;
   logic [TB_W-1:0] gate_len = '0;
   logic            start = 1'b0;
   logic            clr_done = 1'b0, clr_mc_ovf = 1'b0, clr_tb_ovf = 1'b0;
   logic            busy, done_flag, mc_ovf_flag, tb_ovf_flag, irq;
   logic [MC_W-1:0] mc_value;

   int checks = 0;
   int errors = 0;
   int busy_cyc = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   rf_meas #(.MC_W(MC_W), .TB_W(TB_W)) u0 (
      .clk(clk), .rst_n(rst_n), .osc_in(osc_in),
      .preset_wr(preset_wr), .preset_val(preset_val), .gate_len(gate_len),
      .start(start), .clr_done(clr_done), .clr_mc_ovf(clr_mc_ovf),
      .clr_tb_ovf(clr_tb_ovf), .busy(busy), .mc_value(mc_value),
      .done_flag(done_flag), .mc_ovf_flag(mc_ovf_flag),
      .tb_ovf_flag(tb_ovf_flag), .irq(irq)
   );

   always @(negedge clk) if (busy) busy_cyc++;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic osc_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         osc_in = 1'b1; step(4);
         osc_in = 1'b0; step(4);
      end
   endtask

   task automatic set_preset(input logic [MC_W-1:0] v);
      preset_val = v; preset_wr = 1'b1; step(1); preset_wr = 1'b0;
   endtask

   task automatic go(input logic [TB_W-1:0] g);
      gate_len = g; busy_cyc = 0;
      start = 1'b1; step(1); start = 1'b0;
   endtask

   task automatic wait_idle();
      int guard = 0;
      while (busy && guard < 70000) begin step(1); guard++; end
      step(1);
   endtask

   task automatic t_reset();
      check("R1 busy", busy, 0);
      check("R1 flags", {done_flag, mc_ovf_flag, tb_ovf_flag}, 0);
      check("R1 irq", irq, 0);
      check("R1 mc_value", mc_value, 0);
   endtask

   task automatic t_normal();
      set_preset(20'd100);
      go(16'd50);
      check("R2 busy after start", busy, 1);
      osc_pulses(5);
      wait_idle();
      check("R2 gate length", busy_cyc, 50);
      check("R2 done", done_flag, 1);
      check("R3 count", mc_value, 105);
      check("R7 no mc ovf", mc_ovf_flag, 0);
      check("R10 irq on done", irq, 1);
   endtask

   task automatic t_frozen();
      osc_pulses(3);
      set_preset(20'd9);
      step(4);
      check("R4 frozen", mc_value, 105);
   endtask

   task automatic t_clear_done();
      clr_done = 1'b1; step(1); clr_done = 1'b0;
      check("R9 done cleared", done_flag, 0);
      check("R10 irq low", irq, 0);
   endtask

   task automatic t_restart_busy();
      set_preset(20'd0);
      go(16'd40);
      step(8);
      start = 1'b1; step(1); start = 1'b0;
      osc_pulses(2);
      wait_idle();
      check("R5 gate unchanged", busy_cyc, 40);
      check("R5 count unchanged", mc_value, 2);
      clr_done = 1'b1; step(1); clr_done = 1'b0;
   endtask

   task automatic t_mc_overflow();
      set_preset(20'hFFFFD);
      go(16'd200);
      preset_wr = 1'b1; preset_val = 20'd7; step(1); preset_wr = 1'b0;
      osc_pulses(5);
      check("R7 aborted", busy, 0);
      check("R7 wrapped", mc_value, 0);
      check("R7 mc flag", mc_ovf_flag, 1);
      check("R7 no done", done_flag, 0);
      check("R10 irq on ovf", irq, 1);
      step(2);
      check("R9 sticky", mc_ovf_flag, 1);
   endtask

   task automatic t_preset_busy();
      go(16'd10);
      wait_idle();
      check("R6 old preset kept", mc_value, 20'hFFFFD);
      clr_done = 1'b1; step(1); clr_done = 1'b0;
   endtask

   task automatic t_tb_overflow();
      set_preset(20'd0);
      go(16'd0);
      wait_idle();
      check("R8 wrap length", busy_cyc, 65536);
      check("R8 tb flag", tb_ovf_flag, 1);
      check("R8 no done", done_flag, 0);
      clr_tb_ovf = 1'b1; step(1); clr_tb_ovf = 1'b0;
      check("R9 tb cleared", tb_ovf_flag, 0);
      check("R9 mc kept", mc_ovf_flag, 1);
      check("R10 irq still", irq, 1);
      clr_mc_ovf = 1'b1; step(1); clr_mc_ovf = 1'b0;
      check("R9 mc cleared", mc_ovf_flag, 0);
      check("R10 irq released", irq, 0);
   endtask

   initial begin
      step(3);
      t_reset();
      rst_n = 1'b1;
      step(2);
      t_normal();
      t_frozen();
      t_clear_done();
      t_restart_busy();
      t_mc_overflow();
      t_preset_busy();
      t_tb_overflow();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d expected below 190000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule